// File: doc/BRIEF.md
# MDIO Management Master with Single Command Word

This block drives a Clause 22 management bus toward one or more PHYs. The host sees three registers. A command/status word at offset 0x00 holds the PHY address, the register number, the operation, the data, a busy flag and a read-valid flag. A completion cause register sits at offset 0x7C and a cause mask register at 0x80. One write of the command word while the block is idle starts a complete management frame. The frame has 32 preamble ones, start `01`, the opcode, the PHY address, the register address, a turnaround and 16 data bits, all most significant bit first. The host then polls the busy flag or waits for the interrupt.

MDC is divided from the system clock. Each MDC half period lasts `HALF_DIV` system clocks, so a frame is 64 MDC periods long. The output data changes just after a falling MDC edge. For a read, the block releases the data line from the turnaround to the end of the frame and samples the PHY on the rising MDC edge. The captured word appears in the data field together with the read-valid flag.

The frame sequencer has three states. `ST_IDLE` moves to `ST_SHIFT` on an accepted command. `ST_SHIFT` moves to `ST_TAIL` on the rising MDC edge of the last bit. `ST_TAIL` moves back to `ST_IDLE` on the closing falling MDC edge, and that transition is the completion event.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, every register reads zero, and MDC, the data-drive enable and the interrupt are low.
- R2: A write to offset 0x00 while idle loads the fields of the command word and sets busy (bit 28) from the next cycle. The fields are data in bits 15:0, PHY address in 20:16, register number in 25:21, and operation in bit 26, where 1 means read and 0 means write. The same write clears read-valid (bit 27).
- R3: The frame is 32 ones, then `01`, then opcode `10` for a read or `01` for a write, then PHY address, register address, turnaround `10` on writes, and 16 data bits. Bits go out most significant first, and each bit changes only when MDC falls.
- R4: MDC stays low when idle. During a frame it toggles every `HALF_DIV` system clocks, starting low, and busy stays set for exactly 128·`HALF_DIV` cycles.
- R5: During a read, the drive enable is low from the first turnaround bit through the last data bit, and the input is sampled at each rising MDC edge.
- R6: When a read completes, the captured word is in bits 15:0 and read-valid is set in the same cycle in which busy clears. A completed write leaves read-valid at 0.
- R7: A command write while busy is set is ignored. The word's contents and the frame in progress stay unchanged.
- R8: Completion sets cause bit 4 at offset 0x7C. Writing 0 to that bit clears it and writing 1 keeps it. If completion and a clearing write fall in the same cycle, completion wins.
- R9: Mask bit 4 at offset 0x80 is writable. The interrupt is high exactly while cause bit 4 and mask bit 4 are both 1.
- R10: Offsets other than 0x00, 0x7C and 0x80 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Completion interrupt |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Drive enable for `mdio_out` |
| mdio_in | input | 1 | Management data seen on the line |

## Verification
Two events can land on the same clock edge. One is the frame completion that sets the cause bit. The other is a host write that clears that cause bit. The bench provokes the overlap by watching its own model's countdown of remaining busy cycles and driving a zero write to offset 0x7C in the cycle just before the closing edge. It judges the result by requiring that the cause bit and, with the mask set, the interrupt read 1 afterwards. A cycle-by-cycle model, built only from frame timing, predicts every register view, MDC, the drive enable and every driven bit. A behavioural PHY on the wire checks write turnarounds, serves reads from its own storage and checks that the line is released during reads.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} mdio_state_e;

    localparam int FRAME_BITS = 64;
    localparam int TA_IDX     = 46;
    localparam int DATA_IDX   = 48;

    localparam int PHY_LSB    = 16;
    localparam int REG_LSB    = 21;
    localparam int OP_BIT     = 26;
    localparam int VALID_BIT  = 27;
    localparam int BUSY_BIT   = 28;
    localparam int DONE_BIT   = 4;

    localparam logic [7:0] OFS_CMD   = 8'h00;
    localparam logic [7:0] OFS_CAUSE = 8'h7C;
    localparam logic [7:0] OFS_MASK  = 8'h80;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        rise_stb = run && (cnt == LAST) && !mdc;
        fall_stb = run && (cnt == LAST) && mdc;
    end

    // R4
    mdc_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $past(run));
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        start_rd,
    input  logic [4:0]  start_phy,
    input  logic [4:0]  start_reg,
    input  logic [15:0] start_wdata,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_in,
    output logic        run,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rd_data
);
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

    mdio_state_e          state, next_state;
    logic [FRAME_BITS-1:0] shreg;
    logic [IW-1:0]         bit_idx;
    logic                  rd_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:  if (start) next_state = ST_SHIFT;
            ST_SHIFT: if (rise_stb && bit_idx == LAST_IDX) next_state = ST_TAIL;
            ST_TAIL:  if (fall_stb) next_state = ST_IDLE;
            default:  next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
            rd_op   <= 1'b0;
            rd_data <= '0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                shreg   <= {32'hFFFF_FFFF, 2'b01, (start_rd ? 2'b10 : 2'b01),
                            start_phy, start_reg, 2'b10, start_wdata};
                bit_idx <= '0;
                rd_op   <= start_rd;
                rd_data <= '0;
            end
        end else if (state == ST_SHIFT) begin
            if (rise_stb && rd_op && bit_idx >= IW'(DATA_IDX))
                rd_data <= {rd_data[14:0], mdio_in};
            if (fall_stb) begin
                shreg   <= shreg << 1;
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    always_comb begin
        run      = (state != ST_IDLE);
        mdio_out = shreg[FRAME_BITS-1];
        mdio_oe  = run && !(rd_op && bit_idx >= IW'(TA_IDX));
        done     = (state == ST_TAIL) && fall_stb;
    end

    // R3
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) == ST_SHIFT && !$past(fall_stb))
        |-> $stable(mdio_out));
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic [15:0] c_data;
    logic [4:0]  c_phy, c_reg;
    logic        c_rd, c_valid, c_busy;
    logic        cause_done, mask_done;
    logic        start, run, rise_stb, fall_stb, done;
    logic [15:0] fsm_rd_data;

    assign start = reg_wr && (reg_addr == OFS_CMD) && !c_busy;

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) clkgen_i (
        .clk(clk), .rst_n(rst_n), .run(run),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_frame_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_rd(reg_wdata[OP_BIT]),
        .start_phy(reg_wdata[PHY_LSB +: 5]),
        .start_reg(reg_wdata[REG_LSB +: 5]),
        .start_wdata(reg_wdata[15:0]),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_in(mdio_in),
        .run(run), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .done(done), .rd_data(fsm_rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_data  <= '0;
            c_phy   <= '0;
            c_reg   <= '0;
            c_rd    <= 1'b0;
            c_valid <= 1'b0;
            c_busy  <= 1'b0;
        end else if (start) begin
            c_data  <= reg_wdata[15:0];
            c_phy   <= reg_wdata[PHY_LSB +: 5];
            c_reg   <= reg_wdata[REG_LSB +: 5];
            c_rd    <= reg_wdata[OP_BIT];
            c_valid <= 1'b0;
            c_busy  <= 1'b1;
        end else if (done) begin
            c_busy <= 1'b0;
            if (c_rd) begin
                c_data  <= fsm_rd_data;
                c_valid <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_done <= 1'b0;
            mask_done  <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == OFS_CAUSE)
                cause_done <= (cause_done & reg_wdata[DONE_BIT]) | done;
            else if (done)
                cause_done <= 1'b1;
            if (reg_wr && reg_addr == OFS_MASK)
                mask_done <= reg_wdata[DONE_BIT];
        end
    end

    always_comb begin
        irq = cause_done & mask_done;
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD:   reg_rdata = {3'b000, c_busy, c_valid, c_rd, c_reg, c_phy, c_data};
            OFS_CAUSE: reg_rdata[DONE_BIT] = cause_done;
            OFS_MASK:  reg_rdata[DONE_BIT] = mask_done;
            default:   reg_rdata = '0;
        endcase
    end

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (c_busy && !c_valid));
    // R6
    valid_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_valid) |-> $fell(c_busy));
    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_busy && reg_wr && reg_addr == OFS_CMD) |=> $stable({c_phy, c_reg, c_rd}));
    // R8
    cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cause_done);
endmodule

// File: tb/mdio_cmd_master_tb_top.sv
module mdio_cmd_master_tb_top;
    localparam int H = 2;
    localparam int FRAME_CYC = 128 * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, mdc, mdio_out, mdio_oe;
    logic        phy_oe = 1'b0, phy_bit = 1'b1;
    logic        mdio_line;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_out : (phy_oe ? phy_bit : 1'b1);

    mdio_cmd_master #(.HALF_DIV(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_line)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] dflt(input logic [9:0] k);
        return {k[9:5] ^ 5'h0A, 1'b1, k[4:0], 5'h13};
    endfunction

    // ---------------- behavioural PHY on the wire ----------------
    logic [15:0] phy_mem [logic [9:0]];
    int   r_state = 0, r_ones = 0, r_cnt = 0, r_k = 0;
    logic [11:0] r_hdr;
    logic [17:0] r_wr;
    logic [15:0] r_val;

    always @(mdc) begin
        if (mdc) begin
            case (r_state)
                0: begin
                    if (mdio_line) r_ones++;
                    else begin
                        if (r_ones >= 32) r_state = 1;
                        r_ones = 0;
                    end
                end
                1: r_state = mdio_line ? 2 : 0;
                2: begin
                    r_hdr = {r_hdr[10:0], mdio_line};
                    r_cnt++;
                    if (r_cnt == 12) begin
                        r_cnt = 0;
                        if (r_hdr[11:10] == 2'b10) begin
                            r_state = 3;
                            r_k = 0;
                            r_val = phy_mem.exists(r_hdr[9:0]) ? phy_mem[r_hdr[9:0]] : dflt(r_hdr[9:0]);
                        end else if (r_hdr[11:10] == 2'b01) r_state = 4;
                        else begin
                            check(0, "R3 opcode", {20'b0, r_hdr}, 32'h0);
                            r_state = 0;
                        end
                    end
                end
                3: check(!mdio_oe, "R5 released", {31'b0, mdio_oe}, 32'h0);
                4: begin
                    r_wr = {r_wr[16:0], mdio_line};
                    r_cnt++;
                    if (r_cnt == 18) begin
                        check(r_wr[17:16] == 2'b10, "R3 turnaround", {30'b0, r_wr[17:16]}, 32'h2);
                        phy_mem[r_hdr[9:0]] = r_wr[15:0];
                        r_cnt = 0;
                        r_state = 0;
                        r_ones = 0;
                    end
                end
                default: r_state = 0;
            endcase
        end else if (r_state == 3) begin
            if (r_k == 0) phy_oe = 1'b0;
            else if (r_k == 1) begin phy_oe = 1'b1; phy_bit = 1'b0; end
            else if (r_k <= 17) phy_bit = r_val[17 - r_k];
            else begin phy_oe = 1'b0; r_state = 0; r_ones = 0; end
            r_k++;
        end
    end

    // ---------------- cycle reference model ----------------
    int          m_cnt;
    logic [15:0] m_data;
    logic [4:0]  m_phy, m_reg;
    logic        m_rd, m_valid, m_cause, m_mask;
    logic [63:0] m_frame;
    logic [15:0] exp_mem [logic [9:0]];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_data <= '0; m_phy <= '0; m_reg <= '0;
            m_rd <= 0; m_valid <= 0; m_cause <= 0; m_mask <= 0; m_frame <= '0;
        end else begin
            if (reg_wr && reg_addr == 8'h00 && m_cnt == 0) begin
                m_cnt   <= FRAME_CYC;
                m_data  <= reg_wdata[15:0];
                m_phy   <= reg_wdata[20:16];
                m_reg   <= reg_wdata[25:21];
                m_rd    <= reg_wdata[26];
                m_valid <= 1'b0;
                m_frame <= {32'hFFFF_FFFF, 2'b01, (reg_wdata[26] ? 2'b10 : 2'b01),
                            reg_wdata[20:16], reg_wdata[25:21], 2'b10, reg_wdata[15:0]};
                if (!reg_wdata[26]) exp_mem[{reg_wdata[20:16], reg_wdata[25:21]}] = reg_wdata[15:0];
            end else if (m_cnt > 0) begin
                m_cnt <= m_cnt - 1;
                if (m_cnt == 1 && m_rd) begin
                    m_data  <= exp_mem.exists({m_phy, m_reg}) ? exp_mem[{m_phy, m_reg}] : dflt({m_phy, m_reg});
                    m_valid <= 1'b1;
                end
            end
            if (reg_wr && reg_addr == 8'h7C) m_cause <= (m_cause & reg_wdata[4]) | (m_cnt == 1);
            else if (m_cnt == 1) m_cause <= 1'b1;
            if (reg_wr && reg_addr == 8'h80) m_mask <= reg_wdata[4];
        end
    end

    always begin
        @(posedge clk);
        #1;
        if (rst_n) begin
            logic [31:0] er;
            int e, b;
            logic emdc, eoe;
            e = FRAME_CYC - m_cnt;
            b = e / (2 * H);
            emdc = (m_cnt != 0) && ((e / H) % 2 == 1);
            eoe  = (m_cnt != 0) && !(m_rd && b >= 46);
            case (reg_addr)
                8'h00: er = {3'b000, (m_cnt != 0), m_valid, m_rd, m_reg, m_phy, m_data};
                8'h7C: er = {27'b0, m_cause, 4'b0};
                8'h80: er = {27'b0, m_mask, 4'b0};
                default: er = '0;
            endcase
            check(reg_rdata == er, "R2/R6/R7/R8/R10 register view", reg_rdata, er);
            check(irq == (m_cause & m_mask), "R9 irq", {31'b0, irq}, {31'b0, m_cause & m_mask});
            check(mdc == emdc, "R4 mdc", {31'b0, mdc}, {31'b0, emdc});
            check(mdio_oe == eoe, "R5 drive enable", {31'b0, mdio_oe}, {31'b0, eoe});
            if (eoe) check(mdio_out == m_frame[63 - b], "R3 frame bit", {31'b0, mdio_out}, {31'b0, m_frame[63 - b]});
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h00;
    endtask

    function automatic logic [31:0] cmd(input bit rd, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        return {5'b0, rd, r, p, d};
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (m_cnt != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_addr = 8'h00;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check(reg_rdata == 0 && !mdc && !mdio_oe && !irq, "R1 reset state", reg_rdata, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        peek(8'h7C, v); check(v == 0, "R1 cause after reset", v, 0);
        peek(8'h80, v); check(v == 0, "R1 mask after reset", v, 0);

        wr(8'h80, 32'h10);                         // R9 mask on
        wr(8'h00, cmd(0, 5'd5, 5'd3, 16'hA5C3));   // R2 write frame
        wait_idle();
        peek(8'h00, v); check(v[27] == 0, "R6 write leaves valid low", v, 0);
        check(irq, "R9 irq after write", {31'b0, irq}, 1);

        wr(8'h7C, ~32'h10);                        // R8 clear with inverse
        peek(8'h7C, v); check(v == 0, "R8 cleared", v, 0);

        wr(8'h00, cmd(1, 5'd5, 5'd3, 16'h0000));   // R6 read back
        wait_idle();
        peek(8'h00, v); check(v[15:0] == 16'hA5C3 && v[27], "R6 read data", v, {4'h0, 1'b1, 11'h0, 16'hA5C3});

        wr(8'h7C, 32'hFFFF_FFFF);                  // R8 write one keeps
        peek(8'h7C, v); check(v == 32'h10, "R8 write one keeps", v, 32'h10);

        wr(8'h00, cmd(1, 5'h1F, 5'h1F, 16'h1234)); // boundary addresses, default content
        wait_idle();
        peek(8'h00, v); check(v[15:0] == dflt(10'h3FF), "R5 read all-ones address", v, {16'h0, dflt(10'h3FF)});

        wr(8'h00, cmd(0, 5'd0, 5'd0, 16'hFFFF));
        wait_idle();
        wr(8'h00, cmd(1, 5'd0, 5'd0, 16'h0));
        // R7: command while busy must be ignored
        repeat (10) @(negedge clk);
        wr(8'h00, cmd(0, 5'd9, 5'd9, 16'h5555));
        wait_idle();
        peek(8'h00, v); check(v[26] && v[20:16] == 0 && v[15:0] == 16'hFFFF, "R7 busy write ignored", v, {5'b0, 1'b1, 10'b0, 16'hFFFF});

        wr(8'h00, cmd(0, 5'd0, 5'd0, 16'h0000));
        wait_idle();
        wr(8'h00, cmd(1, 5'd0, 5'd0, 16'hBEEF));
        wait_idle();
        peek(8'h00, v); check(v[15:0] == 16'h0000 && v[27], "R6 read zero word", v, 32'h0800_0000);

        // R8 collision: clear lands on the completion edge (cause already 1)
        wr(8'h00, cmd(0, 5'd7, 5'd12, 16'h0F0F));
        @(negedge clk);
        while (m_cnt != 1) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h7C; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h00;
        peek(8'h7C, v); check(v == 32'h10, "R8 completion beats clear", v, 32'h10);
        check(irq, "R9 irq after collision", {31'b0, irq}, 1);

        wr(8'h80, 32'h0);
        @(negedge clk); check(!irq, "R9 masked", {31'b0, irq}, 0);
        peek(8'h40, v); check(v == 0, "R10 unmapped offset", v, 0);
        wr(8'h00, cmd(1, 5'd7, 5'd12, 16'h0));
        wait_idle();
        peek(8'h00, v); check(v[15:0] == 16'h0F0F, "R3 write data on wire", v, 32'h0F0F);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule